// File: doc/BRIEF.md
# Byte-Lane Steering Bus Adapter

This block connects an internal requester to an external data bus that is 16 bits wide. The bus has two byte lanes: the upper lane on bits 15..8 and the lower lane on bits 7..0. A request carries one of three sizes (byte, word or longword), an address, a direction and up to 32 bits of write data. The adapter drives the lane strobes and places the data on the lane that the address selects. The even byte of each halfword goes on the upper lane.

A bus cycle carries one byte or one word. A longword is sent as two word cycles, one after the other: the high half goes first at the base address, then the low half at the base address plus 2. A word or longword request at an odd address is rejected before any bus cycle starts. On reads, the returned lanes are packed into a right-justified 32-bit result. That result arrives with a single response pulse once the last bus cycle has finished.

Top module: `bus_lane_adapter`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_cyc` and `rsp_valid` are 0. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. Size codes are 00 = byte, 01 = word, 10 or 11 = longword.
- R2: A byte access at an even address (bit 0 = 0) asserts only `bus_hi_stb`. The write byte `req_wdata[7:0]` goes on bus bits 15..8 and bits 7..0 are driven to zero.
- R3: A byte access at an odd address asserts only `bus_lo_stb`. The write byte goes on bus bits 7..0 and bits 15..8 are driven to zero.
- R4: A word access runs one bus cycle at the request address with both strobes asserted, carrying `req_wdata[15:0]`.
- R5: A longword access runs two bus cycles. The first is at the base address with `req_wdata[31:16]`. The second is at the base address plus 2 (modulo the address width) with `req_wdata[15:0]`. Both cycles assert both strobes.
- R6: A word or longword request with address bit 0 set starts no bus cycle. In the next cycle it gives a response with `rsp_align_err` = 1 and `rsp_rdata` = 0.
- R7: A byte read returns the selected lane in `rsp_rdata[7:0]`: the upper lane for an even address, the lower lane for an odd one. Bits 31..8 are zero.
- R8: A word read returns `{16'h0, bus_rdata}`. A longword read returns `{first cycle data, second cycle data}`.
- R9: A bus cycle keeps `bus_cyc`, address, strobes, direction and write data stable until `bus_done` is sampled high on a rising edge.
- R10: `req_ready` is 0 from acceptance until the response cycle has passed. `rsp_valid` is a one-cycle pulse in the cycle after the edge that ends the last bus cycle, and `req_ready` returns to 1 in the cycle after that.
- R11: `bus_we` equals the request direction during a bus cycle. A write response carries `rsp_rdata` = 0 and `rsp_align_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 1x longword |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data, right-justified |
| rsp_align_err | output | 1 | Request rejected as misaligned |
| bus_cyc | output | 1 | External bus cycle in progress |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_we | output | 1 | Bus cycle direction, 1 = write |
| bus_hi_stb | output | 1 | Upper lane (15..8) strobe |
| bus_lo_stb | output | 1 | Lower lane (7..0) strobe |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_done | input | 1 | Ends the current bus cycle when high at an edge |

## Verification
The assertions check the following on every cycle:
- a bus cycle always has at least one strobe;
- the idle lane of a write is zero;
- the cycle outputs hold steady while `bus_done` is low;
- a longword's second cycle lands two bytes above the first;
- ready stays low while busy;
- the response is a single pulse;
- a misaligned request never reaches the bus.

The actual lane chosen for each size and address parity, the order of the longword halves, and the packing of read data can only be shown by the bench's sweeps. The bench covers every size, direction, address parity and several bus latencies, including a longword whose second address wraps around.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;
    localparam int XFER_W = 2 * BUS_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    function automatic logic sz_is_byte(input logic [1:0] sz);
        return sz == 2'b00;
    endfunction

    function automatic logic sz_is_long(input logic [1:0] sz);
        return sz[1];
    endfunction
endpackage

// File: rtl/bl_lane_steer.sv
module bl_lane_steer
    import bl_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              addr_lsb,
    input  logic              beat,
    input  logic [XFER_W-1:0] wdata,
    output logic              hi_stb,
    output logic              lo_stb,
    output logic [BUS_W-1:0]  lane_data
);
    logic [BUS_W-1:0] half;

    always_comb begin
        // the first beat of a longword carries the upper half
        half = (sz_is_long(size) && !beat) ? wdata[XFER_W-1:BUS_W] : wdata[BUS_W-1:0];
        if (sz_is_byte(size)) begin
            hi_stb    = !addr_lsb;
            lo_stb    = addr_lsb;
            lane_data = addr_lsb ? {{LANE_W{1'b0}}, wdata[LANE_W-1:0]}
                                 : {wdata[LANE_W-1:0], {LANE_W{1'b0}}};
        end else begin
            hi_stb    = 1'b1;
            lo_stb    = 1'b1;
            lane_data = half;
        end
    end
endmodule

// File: rtl/bl_read_pack.sv
module bl_read_pack
    import bl_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              addr_lsb,
    input  logic              beat,
    input  logic [BUS_W-1:0]  lane_in,
    input  logic [XFER_W-1:0] acc_in,
    output logic [XFER_W-1:0] acc_out
);
    always_comb begin
        if (sz_is_byte(size)) begin
            acc_out = {{(XFER_W-LANE_W){1'b0}},
                       addr_lsb ? lane_in[LANE_W-1:0] : lane_in[BUS_W-1:LANE_W]};
        end else if (!sz_is_long(size)) begin
            acc_out = {{(XFER_W-BUS_W){1'b0}}, lane_in};
        end else if (!beat) begin
            acc_out = {lane_in, acc_in[BUS_W-1:0]};
        end else begin
            acc_out = {acc_in[XFER_W-1:BUS_W], lane_in};
        end
    end
endmodule

// File: rtl/bus_lane_adapter.sv
module bus_lane_adapter
    import bl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_align_err,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_hi_stb,
    output logic              bus_lo_stb,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_done
);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(BUS_W / LANE_W);

    typedef struct packed {
        state_e              st;
        logic                we;
        logic [1:0]          sz;
        logic [ADDR_W-1:0]   addr;
        logic                beat;
        logic                err;
        logic [XFER_W-1:0]   wdata;
        logic [XFER_W-1:0]   rdata;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              stb_hi, stb_lo;
    logic [BUS_W-1:0]  lane_wd;
    logic [XFER_W-1:0] packed_rd;

    bl_lane_steer u_steer (
        .size      (ctx_q.sz),
        .addr_lsb  (ctx_q.addr[0]),
        .beat      (ctx_q.beat),
        .wdata     (ctx_q.wdata),
        .hi_stb    (stb_hi),
        .lo_stb    (stb_lo),
        .lane_data (lane_wd)
    );

    bl_read_pack u_pack (
        .size     (ctx_q.sz),
        .addr_lsb (ctx_q.addr[0]),
        .beat     (ctx_q.beat),
        .lane_in  (bus_rdata),
        .acc_in   (ctx_q.rdata),
        .acc_out  (packed_rd)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.we    = req_write;
                    ctx_d.sz    = req_size;
                    ctx_d.addr  = req_addr;
                    ctx_d.wdata = req_wdata;
                    ctx_d.beat  = 1'b0;
                    ctx_d.rdata = '0;
                    if (!sz_is_byte(req_size) && req_addr[0]) begin
                        ctx_d.err = 1'b1;
                        ctx_d.st  = ST_RESP;
                    end else begin
                        ctx_d.err = 1'b0;
                        ctx_d.st  = ST_BUS;
                    end
                end
            end
            ST_BUS: begin
                if (bus_done) begin
                    if (!ctx_q.we) ctx_d.rdata = packed_rd;
                    if (sz_is_long(ctx_q.sz) && !ctx_q.beat) begin
                        ctx_d.beat = 1'b1;
                    end else begin
                        ctx_d.st = ST_RESP;
                    end
                end
            end
            ST_RESP: ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, we: 1'b0, sz: 2'b00, addr: '0, beat: 1'b0,
                       err: 1'b0, wdata: '0, rdata: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready     = (ctx_q.st == ST_IDLE);
    assign rsp_valid     = (ctx_q.st == ST_RESP);
    assign rsp_rdata     = rsp_valid ? ctx_q.rdata : '0;
    assign rsp_align_err = rsp_valid && ctx_q.err;
    assign bus_cyc       = (ctx_q.st == ST_BUS);
    assign bus_addr      = ctx_q.beat ? ctx_q.addr + HALF_STEP : ctx_q.addr;
    assign bus_we        = bus_cyc && ctx_q.we;
    assign bus_hi_stb    = bus_cyc && stb_hi;
    assign bus_lo_stb    = bus_cyc && stb_lo;
    assign bus_wdata     = bus_we ? lane_wd : '0;

    AST_CYC_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_hi_stb || bus_lo_stb)); // R2

    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && !bus_hi_stb) |-> (bus_wdata[15:8] == 8'h00)); // R3

    AST_CYC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_done) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_hi_stb)
                                    && $stable(bus_lo_stb) && $stable(bus_we)
                                    && $stable(bus_wdata))); // R9

    AST_SECOND_HALF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc && bus_done)) |-> (bus_addr == $past(bus_addr) + HALF_STEP)); // R5

    AST_MISALIGN_SKIPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size != 2'b00 && req_addr[0])
            |=> (!bus_cyc && rsp_valid && rsp_align_err && rsp_rdata == 32'h0)); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc || rsp_valid) |-> !req_ready); // R10

    AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R10
endmodule

// File: tb/tb_bus_lane_adapter.sv
module tb_bus_lane_adapter;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_write;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid, rsp_align_err;
    logic [31:0]   rsp_rdata;
    logic          bus_cyc, bus_we, bus_hi_stb, bus_lo_stb, bus_done;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    bus_lane_adapter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_align_err(rsp_align_err),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_hi_stb(bus_hi_stb), .bus_lo_stb(bus_lo_stb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_done(bus_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // data an external device returns for a halfword address
    function automatic logic [15:0] mem_half(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + 8'h33};
    endfunction

    task automatic run(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                       input logic [31:0] wd, input int lat);
        logic          is_byte, is_long, bad;
        int            beats;
        logic [AW-1:0] ba;
        logic [15:0]   exp_wd;
        logic [31:0]   exp_rd;
        is_byte = (sz == 2'b00);
        is_long = sz[1];
        bad     = !is_byte && a[0];
        beats   = is_long ? 2 : 1;
        @(negedge clk);
        chk("R1 ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~wd;
        if (bad) begin
            chk("R6 no bus cycle", {31'b0, bus_cyc}, 32'd0);
            chk("R6 error response", {30'b0, rsp_valid, rsp_align_err}, 32'd3);
            chk("R6 rdata zero", rsp_rdata, 32'd0);
            @(negedge clk);
            chk("R10 ready after error", {30'b0, req_ready, rsp_valid}, 32'd2);
            return;
        end
        for (int b = 0; b < beats; b++) begin
            ba = (b == 1) ? a + 16'd2 : a;
            if (!w) exp_wd = 16'h0;
            else if (is_byte) exp_wd = a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
            else if (is_long && b == 0) exp_wd = wd[31:16];
            else exp_wd = wd[15:0];
            for (int k = 0; k <= lat; k++) begin
                chk("R9 cycle active", {29'b0, bus_cyc, req_ready, rsp_valid}, 32'd4);
                chk(is_long ? "R5 beat address" : "R4 address", {16'b0, bus_addr}, {16'b0, ba});
                if (is_byte)
                    chk(a[0] ? "R3 odd byte strobes" : "R2 even byte strobes",
                        {30'b0, bus_hi_stb, bus_lo_stb}, a[0] ? 32'd1 : 32'd2);
                else
                    chk("R4 R5 both strobes", {30'b0, bus_hi_stb, bus_lo_stb}, 32'd3);
                chk("R11 direction", {31'b0, bus_we}, {31'b0, w});
                chk(is_byte ? "R2 R3 lane data" : "R5 R4 write half", {16'b0, bus_wdata}, {16'b0, exp_wd});
                if (k == lat) begin
                    bus_done = 1'b1; bus_rdata = mem_half(ba);
                end else begin
                    bus_rdata = 16'hFFFF;
                end
                @(negedge clk);
                bus_done = 1'b0; bus_rdata = 16'h0;
            end
        end
        if (w) exp_rd = 32'h0;
        else if (is_byte) exp_rd = {24'h0, a[0] ? mem_half(a)[7:0] : mem_half(a)[15:8]};
        else if (!is_long) exp_rd = {16'h0, mem_half(a)};
        else exp_rd = {mem_half(a), mem_half(a + 16'd2)};
        chk("R10 response pulse", {29'b0, rsp_valid, bus_cyc, req_ready}, 32'd4);
        chk("R11 no error flag", {31'b0, rsp_align_err}, 32'd0);
        chk(w ? "R11 write rdata zero" : (is_byte ? "R7 byte read" : "R8 wide read"), rsp_rdata, exp_rd);
        @(negedge clk);
        chk("R10 ready again", {30'b0, req_ready, rsp_valid}, 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
        req_addr = '0; req_wdata = '0; bus_done = 1'b0; bus_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R1 reset idle", {30'b0, bus_cyc, rsp_valid}, 32'd0);
        for (int w = 0; w < 2; w++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 4; off++)
                    run(w[0], sz[1:0], 16'h0120 + 16'(off),
                        32'hC3A1_5E70 ^ (32'(off) * 32'h0101_0101) ^ 32'(sz << 4),
                        (off + sz + w) % 3);
        run(1'b0, 2'b10, 16'hFFFE, 32'h0, 1);   // R5 second address wraps to 0000
        run(1'b1, 2'b11, 16'hFFFE, 32'h89AB_CDEF, 0);
        run(1'b1, 2'b01, 16'hFFFF, 32'h1234_5678, 0); // R6 misaligned at top
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule